// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block is the processor-side logic that takes an exception and returns from one. Each cycle it looks at four request lines (synchronous, IRQ, FIQ and system error) and a two-bit origin that tells which context the request came from. When one is accepted, it stores the current processor state and the current PC in the banked saved-state and link registers of the target level. It then masks all asynchronous sources and redirects fetch to a handler address taken from a programmable vector table.

An exception-return request undoes the entry. It loads the processor state back from the saved-state register and redirects fetch to the link register. Software controls a four-bit interrupt mask with set and clear operations that carry an immediate. A masked asynchronous request is not taken.

The processor state held by the block is six bits wide: `{level[1:0], mask[3:0]}`. The mask bits, from bit 3 down to bit 0, gate debug, system error, IRQ and FIQ.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `pstate_o` = 6'h0F (level 0, all four mask bits set), `vbar_o`, `spsr_o` and `elr_o` are 0, and `taken`, `pc_load` are 0.
- R2: A write of `vbar_wdata` with `vbar_wr`=1 stores the value with bits [10:0] forced to zero, so the base is always 2 KB aligned.
- R3: When an exception is taken, `pc_target` in the next cycle is the vector base + origin*0x200 + kind*0x80. Kind is encoded synchronous=0, IRQ=1, FIQ=2, system error=3. Origin is encoded 0 = current level on the level-0 stack, 1 = current level on its own stack, 2 = lower level in 64-bit state, 3 = lower level in 32-bit state.
- R4: On entry, `spsr_o` receives the previous `pstate_o`, `elr_o` receives `cur_pc`, and `pstate_o` becomes {TARGET_EL, 4'hF}. All of these are visible one cycle after the request.
- R5: `mask_set` ORs `mask_imm` into `pstate_o[3:0]`, and `mask_clr` clears the bits set in `mask_imm`. When both are given in the same cycle, the clear wins for the bits that the immediate names.
- R6: A system error, FIQ or IRQ request is not taken while its mask bit is 1 (bit 2, bit 0 and bit 1 respectively). An untaken request leaves `taken`, `pc_load` and `pstate_o` unchanged. A synchronous request is never masked.
- R7: With several requests accepted in one cycle, exactly one is taken, in the priority order synchronous, system error, FIQ, IRQ.
- R8: An `eret` with no exception taken sets `pc_load`=1 with `pc_target` = `elr_o` and loads `pstate_o` from `spsr_o` in the next cycle.
- R9: An exception taken in a cycle overrides `eret` and the mask operations of that cycle. An `eret` overrides the mask operations of its cycle.
- R10: `taken` is a one-cycle pulse per accepted exception, with `pc_load`=1 and `taken_kind`/`taken_origin` giving the chosen kind and origin. It is 0 in a cycle that follows no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbar_wr | input | 1 | Write the vector base |
| vbar_wdata | input | PC_W | New vector base (low 11 bits dropped) |
| cur_pc | input | PC_W | PC of the instruction at which an exception is taken |
| req_sync | input | 1 | Synchronous exception request |
| req_irq | input | 1 | IRQ request |
| req_fiq | input | 1 | FIQ request |
| req_serr | input | 1 | System error request |
| origin | input | 2 | Origin context of the request |
| eret | input | 1 | Exception-return request |
| mask_set | input | 1 | OR `mask_imm` into the mask |
| mask_clr | input | 1 | Clear the mask bits named by `mask_imm` |
| mask_imm | input | 4 | Mask immediate |
| pc_load | output | 1 | Redirect fetch to `pc_target` |
| pc_target | output | PC_W | Handler or return address |
| taken | output | 1 | Exception taken pulse |
| taken_kind | output | 2 | Kind of the taken exception |
| taken_origin | output | 2 | Origin of the taken exception |
| pstate_o | output | 6 | Current processor state {level, mask} |
| spsr_o | output | 6 | Saved processor state |
| elr_o | output | PC_W | Saved return address |
| vbar_o | output | PC_W | Vector base |

## Verification
Every result of this block is registered once, so each one is due exactly one cycle after the stimulus. This covers the redirect, the taken pulse with its kind and origin, the saved state and PC, the new mask, the restored state after a return, a mask update and a vector base write. Each scenario task drives its inputs at a falling edge, lets one rising edge pass, and reads the outputs shortly after it, before the next edge. It then releases the inputs. Cases that must have no effect are read back in that same window through `taken`, `pc_load` and `pstate_o`. Pulse outputs are checked once more after an idle cycle to confirm they have dropped.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int PC_W = 32,
  parameter logic [1:0] TARGET_EL = 2'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vbar_wr,
  input  logic [PC_W-1:0] vbar_wdata,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            req_sync,
  input  logic            req_irq,
  input  logic            req_fiq,
  input  logic            req_serr,
  input  logic [1:0]      origin,
  input  logic            eret,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [3:0]      mask_imm,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_target,
  output logic            taken,
  output logic [1:0]      taken_kind,
  output logic [1:0]      taken_origin,
  output logic [5:0]      pstate_o,
  output logic [5:0]      spsr_o,
  output logic [PC_W-1:0] elr_o,
  output logic [PC_W-1:0] vbar_o
);
  localparam int ALIGN = 11;
  localparam int SLOT  = 7;

  logic [3:0] mask;
  assign mask = pstate_o[3:0];

  logic serr_ok, fiq_ok, irq_ok, hit;
  assign serr_ok = req_serr & ~mask[2];
  assign fiq_ok  = req_fiq  & ~mask[0];
  assign irq_ok  = req_irq  & ~mask[1];
  assign hit     = req_sync | serr_ok | fiq_ok | irq_ok;

  logic [1:0] kind_sel;
  always_comb begin
    if (req_sync)     kind_sel = 2'd0;
    else if (serr_ok) kind_sel = 2'd3;
    else if (fiq_ok)  kind_sel = 2'd2;
    else              kind_sel = 2'd1;
  end

  logic [PC_W-1:0] handler;
  assign handler = {vbar_o[PC_W-1:ALIGN], origin, kind_sel, {SLOT{1'b0}}};

  logic [3:0] mask_nxt;
  assign mask_nxt = (mask | (mask_set ? mask_imm : 4'h0)) & ~(mask_clr ? mask_imm : 4'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate_o     <= 6'h0F;
      spsr_o       <= '0;
      elr_o        <= '0;
      vbar_o       <= '0;
      pc_target    <= '0;
      pc_load      <= 1'b0;
      taken        <= 1'b0;
      taken_kind   <= '0;
      taken_origin <= '0;
    end else begin
      taken   <= hit;
      pc_load <= hit | eret;
      if (vbar_wr) vbar_o <= {vbar_wdata[PC_W-1:ALIGN], {ALIGN{1'b0}}};
      if (hit) begin
        spsr_o       <= pstate_o;
        elr_o        <= cur_pc;
        pstate_o     <= {TARGET_EL, 4'hF};
        pc_target    <= handler;
        taken_kind   <= kind_sel;
        taken_origin <= origin;
      end else if (eret) begin
        pstate_o  <= spsr_o;
        pc_target <= elr_o;
      end else begin
        pstate_o[3:0] <= mask_nxt;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] cur_pc,
  input logic            req_sync,
  input logic            eret,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_target,
  input logic            taken,
  input logic [1:0]      taken_kind,
  input logic [1:0]      taken_origin,
  input logic [5:0]      pstate_o,
  input logic [5:0]      spsr_o,
  input logic [PC_W-1:0] elr_o,
  input logic [PC_W-1:0] vbar_o
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  a_r2_vbar_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    vbar_o[10:0] == 11'd0);

  a_r3_handler_addr: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    taken |-> (pc_target[PC_W-1:11] == $past(vbar_o[PC_W-1:11]) &&
               pc_target[10:0] == {taken_origin, taken_kind, 7'd0}));

  a_r4_save: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    taken |-> (elr_o == $past(cur_pc) && spsr_o == $past(pstate_o)));

  a_r4_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> pstate_o[3:0] == 4'hF);

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (taken && taken_kind == 2'd1) |-> !$past(pstate_o[1]));

  a_r6_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (taken && taken_kind == 2'd2) |-> !$past(pstate_o[0]));

  a_r7_sync_first: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (taken && $past(req_sync)) |-> taken_kind == 2'd0);

  a_r8_return: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(eret) && !taken) |-> (pc_load && pc_target == $past(elr_o) &&
                                 pstate_o == $past(spsr_o)));

  a_r10_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> pc_load);
endmodule

bind exc_entry_unit exc_entry_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .req_sync(req_sync), .eret(eret),
  .pc_load(pc_load), .pc_target(pc_target), .taken(taken),
  .taken_kind(taken_kind), .taken_origin(taken_origin), .pstate_o(pstate_o),
  .spsr_o(spsr_o), .elr_o(elr_o), .vbar_o(vbar_o)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
  logic clk = 0, rst_n = 0;
  logic vbar_wr = 0;
  logic [31:0] vbar_wdata = 0, cur_pc = 0;
  logic req_sync = 0, req_irq = 0, req_fiq = 0, req_serr = 0;
  logic [1:0] origin = 0;
  logic eret = 0, mask_set = 0, mask_clr = 0;
  logic [3:0] mask_imm = 0;
  logic pc_load, taken;
  logic [31:0] pc_target, elr_o, vbar_o;
  logic [1:0] taken_kind, taken_origin;
  logic [5:0] pstate_o, spsr_o;

  exc_entry_unit dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic release_all();
    vbar_wr = 0; req_sync = 0; req_irq = 0; req_fiq = 0; req_serr = 0;
    eret = 0; mask_set = 0; mask_clr = 0; mask_imm = 0; origin = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    release_all();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #0.5;
    chk("R1 pstate", pstate_o, 6'h0F);
    chk("R1 vbar", vbar_o, 0);
    chk("R1 spsr", spsr_o, 0);
    chk("R1 elr", elr_o, 0);
    chk("R1 taken", taken, 0);
    chk("R1 pc_load", pc_load, 0);
  endtask

  task automatic t_vbar();
    @(negedge clk) begin vbar_wr = 1; vbar_wdata = 32'h1234_5FFF; end
    step();
    chk("R2 vbar aligned", vbar_o, 32'h1234_5800);
  endtask

  task automatic mask_op(bit s, bit c, logic [3:0] imm);
    @(negedge clk) begin mask_set = s; mask_clr = c; mask_imm = imm; end
    step();
  endtask

  task automatic t_mask();
    mask_op(0, 1, 4'hF); chk("R5 clear all", pstate_o, 6'h00);
    mask_op(1, 0, 4'b0110); chk("R5 set", pstate_o, 6'h06);
    mask_op(0, 1, 4'b0100); chk("R5 clear", pstate_o, 6'h02);
    mask_op(1, 1, 4'b0001); chk("R5 clear wins", pstate_o, 6'h02);
  endtask

  task automatic t_masked_irq();
    @(negedge clk) begin req_irq = 1; origin = 0; end
    step();
    chk("R6 masked irq taken", taken, 0);
    chk("R6 masked irq pc_load", pc_load, 0);
    chk("R6 masked irq pstate", pstate_o, 6'h02);
  endtask

  task automatic t_fiq_entry();
    @(negedge clk) begin req_fiq = 1; origin = 3; cur_pc = 32'h1000_0040; end
    step();
    chk("R10 taken", taken, 1);
    chk("R10 pc_load", pc_load, 1);
    chk("R10 kind", taken_kind, 2);
    chk("R10 origin", taken_origin, 3);
    chk("R3 fiq target", pc_target, 32'h1234_5F00);
    chk("R4 elr", elr_o, 32'h1000_0040);
    chk("R4 spsr", spsr_o, 6'h02);
    chk("R4 pstate", pstate_o, 6'h1F);
    step();
    chk("R10 pulse drops", taken, 0);
    chk("R10 pc_load drops", pc_load, 0);
  endtask

  task automatic t_nested_blocked();
    @(negedge clk) begin req_irq = 1; req_fiq = 1; req_serr = 1; origin = 1; end
    step();
    chk("R6 nested blocked", taken, 0);
    chk("R6 nested pstate", pstate_o, 6'h1F);
  endtask

  task automatic do_eret(logic [31:0] exp_pc, logic [5:0] exp_ps);
    @(negedge clk) eret = 1;
    step();
    chk("R8 pc_load", pc_load, 1);
    chk("R8 taken", taken, 0);
    chk("R8 return pc", pc_target, exp_pc);
    chk("R8 restored pstate", pstate_o, exp_ps);
  endtask

  task automatic entry(bit s, bit se, bit f, bit i, logic [1:0] org, logic [31:0] pc,
                       logic [1:0] exp_kind, logic [31:0] exp_tgt);
    @(negedge clk) begin
      req_sync = s; req_serr = se; req_fiq = f; req_irq = i; origin = org; cur_pc = pc;
    end
    step();
    chk("R7 taken", taken, 1);
    chk("R7 kind", taken_kind, exp_kind);
    chk("R3 target", pc_target, exp_tgt);
  endtask

  task automatic t_priority();
    mask_op(0, 1, 4'hF);
    entry(1, 1, 1, 1, 2, 32'h2000, 0, 32'h1234_5C00);
    do_eret(32'h2000, 6'h00);
    entry(0, 1, 1, 1, 1, 32'h2100, 3, 32'h1234_5B80);
    do_eret(32'h2100, 6'h00);
    entry(0, 0, 1, 1, 0, 32'h2200, 2, 32'h1234_5900);
    do_eret(32'h2200, 6'h00);
    mask_op(1, 0, 4'b0100);
    entry(0, 1, 1, 0, 2, 32'h2300, 2, 32'h1234_5D00);
    do_eret(32'h2300, 6'h04);
    mask_op(1, 0, 4'hF);
    entry(1, 0, 0, 0, 3, 32'h2400, 0, 32'h1234_5E00);
    do_eret(32'h2400, 6'h0F);
    mask_op(0, 1, 4'hF);
  endtask

  task automatic t_override();
    @(negedge clk) begin
      req_sync = 1; origin = 1; cur_pc = 32'h3000; eret = 1; mask_set = 1; mask_imm = 4'h4;
    end
    step();
    chk("R9 exception wins", taken, 1);
    chk("R9 target", pc_target, 32'h1234_5A00);
    chk("R9 spsr no mask op", spsr_o, 6'h00);
    chk("R9 pstate", pstate_o, 6'h1F);
    @(negedge clk) begin eret = 1; mask_set = 1; mask_imm = 4'h8; end
    step();
    chk("R9 eret wins mask", pstate_o, 6'h00);
    chk("R9 eret pc", pc_target, 32'h3000);
  endtask

  initial begin
    t_reset();
    t_vbar();
    t_mask();
    t_masked_irq();
    t_fiq_entry();
    t_nested_blocked();
    do_eret(32'h1000_0040, 6'h02);
    t_priority();
    t_override();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule